// File: doc/BRIEF.md
# Task Reservation Station

The station keeps the meta-data of in-flight tasks in fixed slots. Each slot holds a header (parameter count and a running count of ready parameters) plus one entry per parameter. An entry stores a ready bit, a version index and a link to the next waiting consumer, given as station, slot and entry. A gateway allocates a slot for a task and then delivers that task's parameters. Scalar parameters come straight from the gateway. Memory parameters come from the dependency tracker and carry their version and consumer link. When every parameter of a task is ready, the station asks for the task to be executed.

Ready notices are not broadcast. A consumer that receives a Ready notice records it and passes it on to the consumer linked in that entry. When a task finishes, the station walks through its parameters one per cycle. For each one it sends a drop notice to the dependency tracker, and only after the last drop does it return the slot to the free pool. Free slots are kept as a bitmap that is searched from the lowest index, so a grant takes one cycle. The free count is visible to the gateway at all times. The slot count is a parameter and is small by default.

Top module: `task_rsv_station`

## Requirements
- R1: An allocation message (`msg_kind`=0, parameter count in `msg_idx`) takes the lowest-numbered free slot. One cycle later it raises `alloc_ack` with that slot on `alloc_slot`, and `free_cnt` drops by one.
- R2: An allocation that arrives while no slot is free raises `alloc_nack` one cycle later and changes no state.
- R3: A task allocated with zero parameters is requested for execution (`exec_valid`, `exec_slot`) in the same cycle as its acknowledge.
- R4: A scalar message (`msg_kind`=1) marks its entry ready. The cycle after the message that readies the last parameter, `exec_valid` pulses exactly once for that slot.
- R5: A versioned message (`msg_kind`=2) stores the version and the consumer link in its entry. It counts as ready only when `msg_rdy` is set.
- R6: A Ready message (`msg_kind`=3) marks its entry ready. If the entry holds a consumer link, `fwd_valid` carries that station, slot and entry one cycle later; if it holds none, nothing is forwarded.
- R7: A Ready message for an entry that is already ready has no effect. Nothing is counted and nothing is forwarded.
- R8: A completion accepted at an edge produces drop notices on the following cycles, one per parameter in ascending entry order, each carrying the stored version. The cycle after the last drop (or the next cycle for a task with no parameters), the slot is freed and `rel_busy` falls.
- R9: A completion presented while `rel_busy` is high is ignored.
- R10: A slot freed at an edge cannot be granted to an allocation sampled at that same edge. It becomes available from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| msg_valid | input | 1 | Incoming message present |
| msg_kind | input | 2 | 0 alloc, 1 scalar, 2 versioned, 3 ready |
| msg_slot | input | SW | Target slot |
| msg_idx | input | IW | Entry index, or parameter count for alloc |
| msg_ver | input | VW | Version index (versioned) |
| msg_rdy | input | 1 | Versioned parameter already ready |
| msg_nxt_vld | input | 1 | Consumer link present |
| msg_nxt_stn | input | STW | Link: station |
| msg_nxt_slot | input | SW | Link: slot |
| msg_nxt_idx | input | IW | Link: entry |
| alloc_ack | output | 1 | Allocation granted |
| alloc_nack | output | 1 | Allocation refused |
| alloc_slot | output | SW | Granted slot |
| free_cnt | output | CW | Number of free slots |
| exec_valid | output | 1 | Task ready to execute |
| exec_slot | output | SW | Slot of ready task |
| done_valid | input | 1 | Task completion |
| done_slot | input | SW | Completed slot |
| rel_busy | output | 1 | Release in progress |
| fwd_valid | output | 1 | Forwarded Ready notice |
| fwd_stn | output | STW | Forward target station |
| fwd_slot | output | SW | Forward target slot |
| fwd_idx | output | IW | Forward target entry |
| drop_valid | output | 1 | Drop notice |
| drop_slot | output | SW | Slot being released |
| drop_idx | output | IW | Entry being released |
| drop_ver | output | VW | Version of released entry |

## Verification
Two things can happen in the same cycle: the release sequence frees a slot, and a new allocation is sampled. The bench fills every slot and starts a completion. It then steps idle cycles until its own model shows that the free is due at the coming edge, and presents an allocation at exactly that edge. A nack is expected there, followed by an ack for the freed slot on the next allocation. While the drops are streaming out, Ready and parameter traffic for other slots continues, and a second completion is presented; the model must show that it was ignored.

// File: rtl/trs_pkg.sv
package trs_pkg;
    typedef enum logic [1:0] {
        K_ALLOC  = 2'd0,
        K_SCALAR = 2'd1,
        K_VPARAM = 2'd2,
        K_READY  = 2'd3
    } msg_kind_e;
endpackage

// File: rtl/trs_free_list.sv
module trs_free_list #(
    parameter int NSLOT = 8,
    localparam int SW = $clog2(NSLOT),
    localparam int CW = $clog2(NSLOT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          give,
    input  logic [SW-1:0] give_idx,
    output logic          has_free,
    output logic [SW-1:0] pick_idx,
    output logic [CW-1:0] free_cnt
);
    logic [NSLOT-1:0] free_q, free_d;

    always_comb begin
        has_free = |free_q;
        pick_idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (free_q[i]) pick_idx = SW'(i);
        end
        free_cnt = CW'($countones(free_q));
        free_d = free_q;
        if (take && has_free) free_d[pick_idx] = 1'b0;
        if (give) free_d[give_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) free_q <= '1;
        else        free_q <= free_d;
    end

    // R10
    free_of_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        give |-> !free_q[give_idx]);
endmodule

// File: rtl/trs_release_seq.sv
module trs_release_seq #(
    parameter int SW = 3,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done_valid,
    input  logic [SW-1:0] done_slot,
    input  logic [IW-1:0] done_npar,
    output logic          busy,
    output logic [SW-1:0] cur_slot,
    output logic [IW-1:0] cur_idx,
    output logic          drop_valid,
    output logic          free_req
);
    typedef struct packed {
        logic          busy;
        logic [SW-1:0] slot;
        logic [IW-1:0] idx;
        logic [IW-1:0] n;
    } rel_t;

    rel_t rel_q, rel_d;

    always_comb begin
        rel_d = rel_q;
        if (rel_q.busy) begin
            if (rel_q.idx != rel_q.n) rel_d.idx  = rel_q.idx + IW'(1);
            else                      rel_d.busy = 1'b0;
        end else if (done_valid) begin
            rel_d.busy = 1'b1;
            rel_d.slot = done_slot;
            rel_d.idx  = '0;
            rel_d.n    = done_npar;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rel_q <= '0;
        else        rel_q <= rel_d;
    end

    assign busy       = rel_q.busy;
    assign cur_slot   = rel_q.slot;
    assign cur_idx    = rel_q.idx;
    assign drop_valid = rel_q.busy && (rel_q.idx != rel_q.n);
    assign free_req   = rel_q.busy && (rel_q.idx == rel_q.n);

    // R9
    start_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(done_valid));
endmodule

// File: rtl/task_rsv_station.sv
module task_rsv_station
    import trs_pkg::*;
#(
    parameter int NSLOT = 8,
    parameter int MAXP  = 15,
    parameter int VW    = 8,
    parameter int STW   = 2,
    localparam int SW  = $clog2(NSLOT),
    localparam int IW  = $clog2(MAXP + 1),
    localparam int ENT = 1 << IW,
    localparam int CW  = $clog2(NSLOT + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           msg_valid,
    input  logic [1:0]     msg_kind,
    input  logic [SW-1:0]  msg_slot,
    input  logic [IW-1:0]  msg_idx,
    input  logic [VW-1:0]  msg_ver,
    input  logic           msg_rdy,
    input  logic           msg_nxt_vld,
    input  logic [STW-1:0] msg_nxt_stn,
    input  logic [SW-1:0]  msg_nxt_slot,
    input  logic [IW-1:0]  msg_nxt_idx,
    output logic           alloc_ack,
    output logic           alloc_nack,
    output logic [SW-1:0]  alloc_slot,
    output logic [CW-1:0]  free_cnt,
    output logic           exec_valid,
    output logic [SW-1:0]  exec_slot,
    input  logic           done_valid,
    input  logic [SW-1:0]  done_slot,
    output logic           rel_busy,
    output logic           fwd_valid,
    output logic [STW-1:0] fwd_stn,
    output logic [SW-1:0]  fwd_slot,
    output logic [IW-1:0]  fwd_idx,
    output logic           drop_valid,
    output logic [SW-1:0]  drop_slot,
    output logic [IW-1:0]  drop_idx,
    output logic [VW-1:0]  drop_ver
);
    typedef struct packed {
        logic [NSLOT-1:0][ENT-1:0]          rdy;
        logic [NSLOT-1:0][ENT-1:0][VW-1:0]  ver;
        logic [NSLOT-1:0][ENT-1:0]          nv;
        logic [NSLOT-1:0][ENT-1:0][STW-1:0] nstn;
        logic [NSLOT-1:0][ENT-1:0][SW-1:0]  nslot;
        logic [NSLOT-1:0][ENT-1:0][IW-1:0]  nidx;
        logic [NSLOT-1:0][IW-1:0]           npar;
        logic [NSLOT-1:0][IW-1:0]           rcnt;
        logic                               ack;
        logic                               nack;
        logic [SW-1:0]                      aslot;
        logic                               exec_v;
        logic [SW-1:0]                      exec_s;
        logic                               fwd_v;
        logic [STW-1:0]                     fwd_stn;
        logic [SW-1:0]                      fwd_slot;
        logic [IW-1:0]                      fwd_idx;
    } st_t;

    st_t       st_q, st_d;
    msg_kind_e kind;
    logic      take, has_free, free_req, do_mark, in_rng;
    logic [SW-1:0] pick_idx;

    assign kind   = msg_kind_e'(msg_kind);
    assign take   = msg_valid && (kind == K_ALLOC);
    assign in_rng = msg_idx < st_q.npar[msg_slot];

    trs_free_list #(.NSLOT(NSLOT)) free_i (
        .clk(clk), .rst_n(rst_n), .take(take), .give(free_req),
        .give_idx(drop_slot), .has_free(has_free), .pick_idx(pick_idx),
        .free_cnt(free_cnt)
    );

    trs_release_seq #(.SW(SW), .IW(IW)) rel_i (
        .clk(clk), .rst_n(rst_n), .done_valid(done_valid),
        .done_slot(done_slot), .done_npar(st_q.npar[done_slot]),
        .busy(rel_busy), .cur_slot(drop_slot), .cur_idx(drop_idx),
        .drop_valid(drop_valid), .free_req(free_req)
    );

    always_comb begin
        st_d        = st_q;
        st_d.ack    = 1'b0;
        st_d.nack   = 1'b0;
        st_d.exec_v = 1'b0;
        st_d.fwd_v  = 1'b0;
        do_mark     = 1'b0;
        if (msg_valid) begin
            case (kind)
                K_ALLOC: begin
                    if (has_free) begin
                        st_d.ack            = 1'b1;
                        st_d.aslot          = pick_idx;
                        st_d.npar[pick_idx] = msg_idx;
                        st_d.rcnt[pick_idx] = '0;
                        st_d.rdy[pick_idx]  = '0;
                        if (msg_idx == '0) begin
                            st_d.exec_v = 1'b1;
                            st_d.exec_s = pick_idx;
                        end
                    end else begin
                        st_d.nack = 1'b1;
                    end
                end
                K_SCALAR: do_mark = in_rng;
                K_VPARAM: begin
                    if (in_rng) begin
                        st_d.ver[msg_slot][msg_idx]   = msg_ver;
                        st_d.nv[msg_slot][msg_idx]    = msg_nxt_vld;
                        st_d.nstn[msg_slot][msg_idx]  = msg_nxt_stn;
                        st_d.nslot[msg_slot][msg_idx] = msg_nxt_slot;
                        st_d.nidx[msg_slot][msg_idx]  = msg_nxt_idx;
                        do_mark = msg_rdy;
                    end
                end
                K_READY: begin
                    if (in_rng && !st_q.rdy[msg_slot][msg_idx]) begin
                        do_mark = 1'b1;
                        if (st_q.nv[msg_slot][msg_idx]) begin
                            st_d.fwd_v    = 1'b1;
                            st_d.fwd_stn  = st_q.nstn[msg_slot][msg_idx];
                            st_d.fwd_slot = st_q.nslot[msg_slot][msg_idx];
                            st_d.fwd_idx  = st_q.nidx[msg_slot][msg_idx];
                        end
                    end
                end
                default: ;
            endcase
        end
        if (do_mark && !st_q.rdy[msg_slot][msg_idx]) begin
            st_d.rdy[msg_slot][msg_idx] = 1'b1;
            st_d.rcnt[msg_slot] = st_q.rcnt[msg_slot] + IW'(1);
            if (st_q.rcnt[msg_slot] + IW'(1) == st_q.npar[msg_slot]) begin
                st_d.exec_v = 1'b1;
                st_d.exec_s = msg_slot;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alloc_ack  = st_q.ack;
    assign alloc_nack = st_q.nack;
    assign alloc_slot = st_q.aslot;
    assign exec_valid = st_q.exec_v;
    assign exec_slot  = st_q.exec_s;
    assign fwd_valid  = st_q.fwd_v;
    assign fwd_stn    = st_q.fwd_stn;
    assign fwd_slot   = st_q.fwd_slot;
    assign fwd_idx    = st_q.fwd_idx;
    assign drop_ver   = st_q.ver[drop_slot][drop_idx];

    // R1
    grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({alloc_ack, alloc_nack}));
    // R2
    refuse_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_nack |-> $past(free_cnt) == '0);
    // R4
    exec_after_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |-> $past(msg_valid));
    // R6
    fwd_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> $past(msg_valid && msg_kind == 2'd3));
    // R8
    drop_in_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_valid |-> rel_busy);
endmodule

// File: tb/task_rsv_station_tb.sv
module task_rsv_station_tb_top;
    localparam int NSLOT = 8;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic msg_valid = 0, msg_rdy = 0, msg_nxt_vld = 0, done_valid = 0;
    logic [1:0] msg_kind = 0, msg_nxt_stn = 0;
    logic [2:0] msg_slot = 0, msg_nxt_slot = 0, done_slot = 0;
    logic [3:0] msg_idx = 0, msg_nxt_idx = 0;
    logic [7:0] msg_ver = 0;
    logic alloc_ack, alloc_nack, exec_valid, rel_busy, fwd_valid, drop_valid;
    logic [2:0] alloc_slot, exec_slot, fwd_slot, drop_slot;
    logic [3:0] free_cnt, fwd_idx, drop_idx;
    logic [1:0] fwd_stn;
    logic [7:0] drop_ver;

    task_rsv_station dut_i (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_kind(msg_kind),
        .msg_slot(msg_slot), .msg_idx(msg_idx), .msg_ver(msg_ver), .msg_rdy(msg_rdy),
        .msg_nxt_vld(msg_nxt_vld), .msg_nxt_stn(msg_nxt_stn), .msg_nxt_slot(msg_nxt_slot),
        .msg_nxt_idx(msg_nxt_idx), .alloc_ack(alloc_ack), .alloc_nack(alloc_nack),
        .alloc_slot(alloc_slot), .free_cnt(free_cnt), .exec_valid(exec_valid),
        .exec_slot(exec_slot), .done_valid(done_valid), .done_slot(done_slot),
        .rel_busy(rel_busy), .fwd_valid(fwd_valid), .fwd_stn(fwd_stn),
        .fwd_slot(fwd_slot), .fwd_idx(fwd_idx), .drop_valid(drop_valid),
        .drop_slot(drop_slot), .drop_idx(drop_idx), .drop_ver(drop_ver)
    );

    int checks = 0, failures = 0;
    bit finished = 0;

    bit m_free[NSLOT];
    int m_npar[NSLOT], m_rcnt[NSLOT];
    bit m_rdy[NSLOT][16], m_nv[NSLOT][16];
    int m_ver[NSLOT][16], m_nstn[NSLOT][16], m_nslot[NSLOT][16], m_nidx[NSLOT][16];
    bit m_busy;
    int m_rslot, m_ridx, m_rn;
    bit e_ack, e_nack, e_exec, e_fwd;
    int e_aslot, e_exec_slot, e_fstn, e_fslot, e_fidx;

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic m_mark(int s, int i);
        if (!m_rdy[s][i]) begin
            m_rdy[s][i] = 1;
            m_rcnt[s]++;
            if (m_rcnt[s] == m_npar[s]) begin
                e_exec = 1;
                e_exec_slot = s;
            end
        end
    endtask

    task automatic compare();
        int fc = 0;
        foreach (m_free[k]) fc += m_free[k];
        chk(alloc_ack == e_ack, "R1 alloc_ack", alloc_ack, e_ack);
        if (e_ack) chk(alloc_slot == e_aslot, "R1 alloc_slot", alloc_slot, e_aslot);
        chk(alloc_nack == e_nack, "R2 alloc_nack", alloc_nack, e_nack);
        chk(free_cnt == fc, "R1 free_cnt", free_cnt, fc);
        chk(exec_valid == e_exec, "R4 exec_valid", exec_valid, e_exec);
        if (e_exec) chk(exec_slot == e_exec_slot, "R4 exec_slot", exec_slot, e_exec_slot);
        chk(fwd_valid == e_fwd, "R6 fwd_valid", fwd_valid, e_fwd);
        if (e_fwd) begin
            chk(fwd_stn == e_fstn, "R6 fwd_stn", fwd_stn, e_fstn);
            chk(fwd_slot == e_fslot, "R6 fwd_slot", fwd_slot, e_fslot);
            chk(fwd_idx == e_fidx, "R6 fwd_idx", fwd_idx, e_fidx);
        end
        chk(rel_busy == m_busy, "R9 rel_busy", rel_busy, m_busy);
        chk(drop_valid == (m_busy && m_ridx != m_rn), "R8 drop_valid",
            drop_valid, m_busy && m_ridx != m_rn);
        if (m_busy && m_ridx != m_rn) begin
            chk(drop_slot == m_rslot, "R8 drop_slot", drop_slot, m_rslot);
            chk(drop_idx == m_ridx, "R8 drop_idx", drop_idx, m_ridx);
            chk(drop_ver == m_ver[m_rslot][m_ridx], "R8 drop_ver",
                drop_ver, m_ver[m_rslot][m_ridx]);
        end
    endtask

    task automatic cyc();
        int s = msg_slot, i = msg_idx;
        e_ack = 0; e_nack = 0; e_exec = 0; e_fwd = 0;
        if (msg_valid) begin
            case (msg_kind)
                0: begin
                    int pick = -1;
                    for (int k = NSLOT - 1; k >= 0; k--) if (m_free[k]) pick = k;
                    if (pick >= 0) begin
                        e_ack = 1; e_aslot = pick; m_free[pick] = 0;
                        m_npar[pick] = msg_idx; m_rcnt[pick] = 0;
                        for (int k = 0; k < 16; k++) m_rdy[pick][k] = 0;
                        if (msg_idx == 0) begin e_exec = 1; e_exec_slot = pick; end
                    end else e_nack = 1;
                end
                1: if (i < m_npar[s]) m_mark(s, i);
                2: if (i < m_npar[s]) begin
                    m_ver[s][i] = msg_ver; m_nv[s][i] = msg_nxt_vld;
                    m_nstn[s][i] = msg_nxt_stn; m_nslot[s][i] = msg_nxt_slot;
                    m_nidx[s][i] = msg_nxt_idx;
                    if (msg_rdy) m_mark(s, i);
                end
                default: if (i < m_npar[s] && !m_rdy[s][i]) begin
                    if (m_nv[s][i]) begin
                        e_fwd = 1; e_fstn = m_nstn[s][i];
                        e_fslot = m_nslot[s][i]; e_fidx = m_nidx[s][i];
                    end
                    m_mark(s, i);
                end
            endcase
        end
        if (m_busy) begin
            if (m_ridx != m_rn) m_ridx++;
            else begin m_busy = 0; m_free[m_rslot] = 1; end
        end else if (done_valid) begin
            m_busy = 1; m_rslot = done_slot; m_ridx = 0; m_rn = m_npar[done_slot];
        end
        @(posedge clk);
        @(negedge clk);
        compare();
        msg_valid = 0; done_valid = 0; msg_rdy = 0; msg_nxt_vld = 0;
    endtask

    task automatic send(int kind, int s, int i);
        msg_valid = 1; msg_kind = kind; msg_slot = s; msg_idx = i;
    endtask
    task automatic do_alloc(int n);
        send(0, 0, n); cyc();
    endtask
    task automatic do_scalar(int s, int i);
        send(1, s, i); cyc();
    endtask
    task automatic do_vp(int s, int i, int ver, bit r, bit nv, int stn, int sl, int ix);
        send(2, s, i); msg_ver = ver; msg_rdy = r; msg_nxt_vld = nv;
        msg_nxt_stn = stn; msg_nxt_slot = sl; msg_nxt_idx = ix; cyc();
    endtask
    task automatic do_ready(int s, int i);
        send(3, s, i); cyc();
    endtask
    task automatic do_done(int s);
        done_valid = 1; done_slot = s; cyc();
    endtask

    initial begin
        foreach (m_free[k]) m_free[k] = 1;
        m_busy = 0; m_rslot = 0; m_ridx = 0; m_rn = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        e_ack = 0; e_nack = 0; e_exec = 0; e_fwd = 0;
        compare();                          // reset state
        do_alloc(0);                        // R3: slot 0, immediate execution
        do_alloc(2);                        // R1: slot 1
        do_scalar(1, 0);                    // R4
        do_scalar(1, 1);                    // R4: exec slot 1
        do_alloc(3);                        // slot 2
        do_vp(2, 0, 5, 0, 1, 1, 6, 3);      // R5: waiting, linked consumer
        do_vp(2, 1, 7, 1, 0, 0, 0, 0);      // R5: arrives ready
        do_scalar(2, 2);
        do_ready(2, 0);                     // R6: forward and exec
        do_ready(2, 0);                     // R7: duplicate, no effect
        do_alloc(1);                        // slot 3
        do_vp(3, 0, 9, 0, 0, 0, 0, 0);
        do_ready(3, 0);                     // R6: no link, no forward
        for (int k = 0; k < 4; k++) do_alloc(2);
        do_alloc(1);                        // R2: full, refused
        do_done(2);                         // R8: three drops
        do_done(1);                         // R9: ignored while busy
        do_ready(4, 0);
        while (!(m_busy && m_ridx == m_rn)) cyc();
        do_alloc(1);                        // R10: freed this edge, still refused
        do_alloc(1);                        // R10: now gets slot 2
        do_done(0);                         // R8: zero-parameter release
        repeat (2) cyc();
        do_alloc(2);
        repeat (3) cyc();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule